// File: doc/BRIEF.md
# Code Memory Lock and Verify Controller

This block protects the on-chip code store of a small microcontroller. Three one-time lock bits set a cumulative protection level. Each level removes one more privilege: programming, table reads of internal code by externally fetched instructions, read-back for verification, and execution from external memory. The block also holds the external-access strap. While the part is protected, it samples the strap level during reset and uses that value afterwards in place of the live pin.

The same block decodes the pin pattern that a programming station applies while the part is held in reset. One pattern reads back code bytes. A second pattern reads a small set of fixed identification bytes. The selected byte appears on a registered read port one clock after the pattern and address are applied. Code bytes are replaced by zero when read-back is forbidden.

Top module: `codelock_ctrl`

## Requirements
- R1: `lock_bits[0]`, `lock_bits[1]` and `lock_bits[2]` are the first, second and third lock bits, and 1 means programmed. The level is the number of consecutive programmed bits counted from bit 0. When bit 0 is clear the level is 0 and `prog_ok`, `movc_int_ok`, `verify_ok` and `ext_exec_ok` are all 1, even if the other bits are set.
- R2: At level 1 or above, `prog_ok` is 0 and `movc_int_ok` equals the inverse of `fetch_ext`.
- R3: At level 2 or above, `verify_ok` is 0. It is 1 below level 2.
- R4: At level 3, `ext_exec_ok` is 0 and `fetch_ext_sel` is 0. Below level 3, `ext_exec_ok` is 1.
- R5: At any clock edge where `rst_lvl` is 1 after block reset, the strap latch takes `ea_lvl` and `ea_latched_vld` becomes 1. At level 1 or above with the latch valid, `ea_eff` equals the latched value and ignores later changes of `ea_lvl`.
- R6: At level 1 or above with no valid latch, `ea_eff` is 1.
- R7: At level 0, `ea_eff` follows `ea_lvl` directly. At every level below 3, `fetch_ext_sel` is the inverse of `ea_eff`.
- R8: The base verify pattern is `rst_lvl`=1, `pstrb_lvl`=0, `alat_lvl`=1, `ea_lvl`=1 and `hsel_lvl`=00. With `ctl_lvl`=11 it selects code read, and `rd_mode` shows 1 after the next clock edge.
- R9: In code read, `rd_data` after the next edge is `code_rdata` when `verify_ok` is 1, and 00H otherwise.
- R10: The base pattern with `ctl_lvl`=00 selects signature read (`rd_mode`=2). It returns 1EH at address 030H, 80H at 031H, 01H at 032H and 00H at any other address, whatever the lock level.
- R11: Any other pin pattern gives `rd_mode`=0 and `rd_data`=00H after the next edge.
- R12: A low `rst_n` at once clears `rd_data`, `rd_mode` and `ea_latched_vld`. Their release is synchronised to `clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Block reset, active low, asynchronous assert |
| lock_bits | input | 3 | Lock bits, 1 = programmed |
| rst_lvl | input | 1 | Level of the device reset pin |
| pstrb_lvl | input | 1 | Level of the program-store strobe pin |
| alat_lvl | input | 1 | Level of the address-latch pin |
| ea_lvl | input | 1 | Level of the external-access strap pin |
| hsel_lvl | input | 2 | Levels of the two high-address mode pins |
| ctl_lvl | input | 2 | Levels of the two control mode pins |
| addr | input | 12 | Verify/signature address |
| code_rdata | input | 8 | Byte read from the code array at `addr` |
| fetch_ext | input | 1 | Current instruction came from external memory |
| prog_ok | output | 1 | Programming permitted |
| movc_int_ok | output | 1 | Table read of internal code permitted |
| verify_ok | output | 1 | Code read-back permitted |
| ext_exec_ok | output | 1 | External execution permitted |
| ea_eff | output | 1 | Strap value in use (1 = internal fetch) |
| ea_latched_vld | output | 1 | Strap latch holds a reset-time sample |
| fetch_ext_sel | output | 1 | Fetch from external memory |
| rd_data | output | 8 | Registered read-back byte |
| rd_mode | output | 2 | Registered mode: 0 none, 1 code, 2 signature |

## Verification
The bench sets the second or third lock bit without the first. A decoder that counts set bits instead of the run from bit 0 would then wrongly drop permissions. It moves the strap pin after a protected reset capture, and again before any capture. A design that reads the live pin, or that defaults to external fetch, would change `ea_eff`. It reads back code at each lock level and signature bytes at the three valid addresses and one beyond them. A wrong threshold would leak code bytes or zero the signature. It also tries single-pin deviations from the verify pattern, which a loose decoder would accept.

// File: rtl/codelock_pkg.sv
package codelock_pkg;

  typedef enum logic [1:0] {
    RDM_IDLE = 2'd0,
    RDM_CODE = 2'd1,
    RDM_SIG  = 2'd2
  } rd_mode_e;

  typedef struct packed {
    logic prog_ok;
    logic guarded;
    logic verify_ok;
    logic ext_exec_ok;
  } perm_t;

endpackage

// File: rtl/cl_rst_sync.sv
module cl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/cl_level_dec.sv
module cl_level_dec
  import codelock_pkg::*;
#(
  parameter int LB_W       = 3,
  parameter int VERIFY_LVL = 2,
  parameter int EXT_LVL    = 3
) (
  input  logic [LB_W-1:0] lock_bits,
  output perm_t           perm
);

  localparam int LVW = $clog2(LB_W + 1);

  logic [LB_W-1:0] run;
  logic [LVW-1:0]  level;

  // run[i] is set only while every bit from 0 up to i is programmed
  generate
    for (genvar i = 0; i < LB_W; i++) begin : g_run
      if (i == 0) begin : g_first
        assign run[i] = lock_bits[i];
      end else begin : g_next
        assign run[i] = run[i-1] & lock_bits[i];
      end
    end
  endgenerate

  always_comb begin
    level = '0;
    for (int i = 0; i < LB_W; i++) begin
      level = level + {{(LVW-1){1'b0}}, run[i]};
    end
  end

  always_comb begin
    perm.prog_ok     = (level == '0);
    perm.guarded     = (level != '0);
    perm.verify_ok   = (level < LVW'(VERIFY_LVL));
    perm.ext_exec_ok = (level < LVW'(EXT_LVL));
  end

endmodule

// File: rtl/cl_strap_latch.sv
module cl_strap_latch (
  input  logic clk,
  input  logic srst_n,
  input  logic rst_lvl,
  input  logic ea_lvl,
  output logic ea_q,
  output logic vld_q
);

  logic cap_en;
  logic vld_d;

  assign cap_en = rst_lvl;

  always_comb begin
    vld_d = vld_q | cap_en;
  end

  // sample register: meaningful only once vld_q is set
  always_ff @(posedge clk) begin
    if (cap_en) begin
      ea_q <= ea_lvl;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
    end
  end

endmodule

// File: rtl/cl_mode_dec.sv
module cl_mode_dec
  import codelock_pkg::*;
(
  input  logic       rst_lvl,
  input  logic       pstrb_lvl,
  input  logic       alat_lvl,
  input  logic       ea_lvl,
  input  logic [1:0] hsel_lvl,
  input  logic [1:0] ctl_lvl,
  output rd_mode_e   mode
);

  logic base_ok;

  assign base_ok = rst_lvl & ~pstrb_lvl & alat_lvl & ea_lvl & (hsel_lvl == 2'b00);

  always_comb begin
    mode = RDM_IDLE;
    if (base_ok) begin
      unique case (ctl_lvl)
        2'b11:   mode = RDM_CODE;
        2'b00:   mode = RDM_SIG;
        default: mode = RDM_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/codelock_ctrl.sv
module codelock_ctrl
  import codelock_pkg::*;
#(
  parameter int                     LB_W      = 3,
  parameter int                     ADDR_W    = 12,
  parameter int                     DATA_W    = 8,
  parameter int                     SIG_N     = 3,
  parameter logic [ADDR_W-1:0]      SIG_BASE  = 12'h030,
  parameter logic [SIG_N*DATA_W-1:0] SIG_BYTES = 24'h01_80_1E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LB_W-1:0]   lock_bits,
  input  logic              rst_lvl,
  input  logic              pstrb_lvl,
  input  logic              alat_lvl,
  input  logic              ea_lvl,
  input  logic [1:0]        hsel_lvl,
  input  logic [1:0]        ctl_lvl,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] code_rdata,
  input  logic              fetch_ext,
  output logic              prog_ok,
  output logic              movc_int_ok,
  output logic              verify_ok,
  output logic              ext_exec_ok,
  output logic              ea_eff,
  output logic              ea_latched_vld,
  output logic              fetch_ext_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic [1:0]        rd_mode
);

  logic        srst_n;
  perm_t       perm;
  logic        ea_q;
  logic        ea_vld;
  rd_mode_e    mode;

  cl_rst_sync #(.STAGES(2)) u_rsync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  cl_level_dec #(.LB_W(LB_W)) u_lvl (
    .lock_bits (lock_bits),
    .perm      (perm)
  );

  cl_strap_latch u_strap (
    .clk     (clk),
    .srst_n  (srst_n),
    .rst_lvl (rst_lvl),
    .ea_lvl  (ea_lvl),
    .ea_q    (ea_q),
    .vld_q   (ea_vld)
  );

  cl_mode_dec u_mode (
    .rst_lvl   (rst_lvl),
    .pstrb_lvl (pstrb_lvl),
    .alat_lvl  (alat_lvl),
    .ea_lvl    (ea_lvl),
    .hsel_lvl  (hsel_lvl),
    .ctl_lvl   (ctl_lvl),
    .mode      (mode)
  );

  // permissions and fetch steering
  logic ea_sel;

  always_comb begin
    if (perm.guarded) begin
      ea_sel = ea_vld ? ea_q : 1'b1;
    end else begin
      ea_sel = ea_lvl;
    end
  end

  assign prog_ok        = perm.prog_ok;
  assign verify_ok      = perm.verify_ok;
  assign ext_exec_ok    = perm.ext_exec_ok;
  assign movc_int_ok    = ~(perm.guarded & fetch_ext);
  assign ea_eff         = ea_sel;
  assign ea_latched_vld = ea_vld;
  assign fetch_ext_sel  = perm.ext_exec_ok & ~ea_sel;

  // signature byte lookup
  logic [SIG_N-1:0]  sig_hit;
  logic [DATA_W-1:0] sig_word;

  generate
    for (genvar i = 0; i < SIG_N; i++) begin : g_sig
      assign sig_hit[i] = (addr == SIG_BASE + ADDR_W'(i));
    end
  endgenerate

  always_comb begin
    sig_word = '0;
    for (int i = 0; i < SIG_N; i++) begin
      if (sig_hit[i]) begin
        sig_word = sig_word | SIG_BYTES[i*DATA_W +: DATA_W];
      end
    end
  end

  // read-back path: next state
  logic [DATA_W-1:0] rd_d;
  logic [DATA_W-1:0] rd_q;
  rd_mode_e          mode_q;
  logic              rd_en;

  always_comb begin
    unique case (mode)
      RDM_CODE: rd_d = perm.verify_ok ? code_rdata : '0;
      RDM_SIG:  rd_d = sig_word;
      default:  rd_d = '0;
    endcase
  end

  assign rd_en = (mode != RDM_IDLE) | (mode_q != RDM_IDLE);

  // read-back path: registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      rd_q   <= '0;
      mode_q <= RDM_IDLE;
    end else if (rd_en) begin
      rd_q   <= rd_d;
      mode_q <= mode;
    end
  end

  assign rd_data = rd_q;
  assign rd_mode = mode_q;

endmodule

// File: rtl/codelock_chk.sv
module codelock_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] lock_bits,
  input logic       fetch_ext,
  input logic       rst_lvl,
  input logic       pstrb_lvl,
  input logic       alat_lvl,
  input logic       ea_lvl,
  input logic [1:0] hsel_lvl,
  input logic [1:0] ctl_lvl,
  input logic       prog_ok,
  input logic       movc_int_ok,
  input logic       verify_ok,
  input logic       ext_exec_ok,
  input logic       ea_eff,
  input logic       ea_latched_vld,
  input logic       fetch_ext_sel,
  input logic [7:0] rd_data,
  input logic [1:0] rd_mode
);

  assert_open_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_bits[0] |-> (prog_ok && movc_int_ok && verify_ok && ext_exec_ok));

  assert_prog_block_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_bits[0] && fetch_ext) |-> (!prog_ok && !movc_int_ok));

  assert_verify_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_bits[0] && lock_bits[1]) |-> !verify_ok);

  assert_ext_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (&lock_bits) |-> (!ext_exec_ok && !fetch_ext_sel));

  assert_strap_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_bits[0] && ea_latched_vld && !rst_lvl) |=> (!lock_bits[0] || ea_eff == $past(ea_eff)));

  assert_no_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_bits[0] && !ea_latched_vld) |-> ea_eff);

  assert_locked_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_lvl && !pstrb_lvl && alat_lvl && ea_lvl && hsel_lvl == 2'b00 &&
     ctl_lvl == 2'b11 && !verify_ok) |=> (rd_data == 8'h00));

  assert_mode_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_mode != 2'b11);

endmodule

bind codelock_ctrl codelock_chk u_chk (.*);

// File: tb/sim_codelock_ctrl.sv
module sim_codelock_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  lock_bits;
  logic        rst_lvl, pstrb_lvl, alat_lvl, ea_lvl, fetch_ext;
  logic [1:0]  hsel_lvl, ctl_lvl;
  logic [11:0] addr;
  logic [7:0]  code_rdata;
  logic        prog_ok, movc_int_ok, verify_ok, ext_exec_ok;
  logic        ea_eff, ea_latched_vld, fetch_ext_sel;
  logic [7:0]  rd_data;
  logic [1:0]  rd_mode;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  codelock_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .lock_bits(lock_bits), .rst_lvl(rst_lvl),
    .pstrb_lvl(pstrb_lvl), .alat_lvl(alat_lvl), .ea_lvl(ea_lvl),
    .hsel_lvl(hsel_lvl), .ctl_lvl(ctl_lvl), .addr(addr), .code_rdata(code_rdata),
    .fetch_ext(fetch_ext), .prog_ok(prog_ok), .movc_int_ok(movc_int_ok),
    .verify_ok(verify_ok), .ext_exec_ok(ext_exec_ok), .ea_eff(ea_eff),
    .ea_latched_vld(ea_latched_vld), .fetch_ext_sel(fetch_ext_sel),
    .rd_data(rd_data), .rd_mode(rd_mode)
  );

  // reference model state
  int   rel_cnt;
  logic m_ea, m_vld;
  int   m_rd, m_mode;

  function automatic int lvl_of(logic [2:0] lb);
    if (!lb[0]) return 0;
    if (!lb[1]) return 1;
    if (!lb[2]) return 2;
    return 3;
  endfunction

  function automatic int mode_of();
    if (rst_lvl && !pstrb_lvl && alat_lvl && ea_lvl && hsel_lvl == 2'b00) begin
      if (ctl_lvl == 2'b11) return 1;
      if (ctl_lvl == 2'b00) return 2;
    end
    return 0;
  endfunction

  function automatic int sig_of(logic [11:0] a);
    case (a)
      12'h030: return 8'h1E;
      12'h031: return 8'h80;
      12'h032: return 8'h01;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst_lvl) m_ea <= ea_lvl;
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel_cnt <= 0; m_vld <= 1'b0; m_rd <= 0; m_mode <= 0;
    end else if (rel_cnt < 2) begin
      rel_cnt <= rel_cnt + 1;
    end else begin
      if (rst_lvl) m_vld <= 1'b1;
      m_mode <= mode_of();
      case (mode_of())
        1: m_rd <= (lvl_of(lock_bits) < 2) ? int'(code_rdata) : 0;
        2: m_rd <= sig_of(addr);
        default: m_rd <= 0;
      endcase
    end
  end

  task automatic chk1(string tag, string nm, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, nm, act, exp);
    end
  endtask

  task automatic compare(string tag);
    int  lv;
    int  eff;
    lv  = lvl_of(lock_bits);
    eff = (lv >= 1) ? (m_vld ? int'(m_ea) : 1) : int'(ea_lvl);
    chk1(tag, "prog_ok",        prog_ok,        lv == 0);
    chk1(tag, "movc_int_ok",    movc_int_ok,    !(lv >= 1 && fetch_ext));
    chk1(tag, "verify_ok",      verify_ok,      lv < 2);
    chk1(tag, "ext_exec_ok",    ext_exec_ok,    lv < 3);
    chk1(tag, "ea_eff",         ea_eff,         eff);
    chk1(tag, "ea_latched_vld", ea_latched_vld, m_vld);
    chk1(tag, "fetch_ext_sel",  fetch_ext_sel,  (lv < 3) && eff == 0);
    chk1(tag, "rd_data",        rd_data,        m_rd);
    chk1(tag, "rd_mode",        rd_mode,        m_mode);
  endtask

  task automatic step(string tag);
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic pins_idle();
    rst_lvl = 0; pstrb_lvl = 1; alat_lvl = 1; ea_lvl = 1;
    hsel_lvl = 2'b00; ctl_lvl = 2'b11;
  endtask

  task automatic pins_verify(logic [1:0] ctl);
    rst_lvl = 1; pstrb_lvl = 0; alat_lvl = 1; ea_lvl = 1;
    hsel_lvl = 2'b00; ctl_lvl = ctl;
  endtask

  initial begin
    rst_n = 0; lock_bits = 3'b000; fetch_ext = 0; addr = '0; code_rdata = 8'hA5;
    pins_idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R12 reset");
    rst_n = 1;
    repeat (3) step("R12 release");

    // R1: unprotected, including non-leading bits set
    for (int v = 0; v < 8; v++) begin
      lock_bits = {v[1:0], 1'b0};
      fetch_ext = v[2];
      ea_lvl = v[0];
      step("R1 R7 open");
    end

    // R6: protected before any strap capture
    lock_bits = 3'b001; ea_lvl = 0; fetch_ext = 1;
    step("R6 no latch");
    step("R2 movc");

    // R5: capture strap = 0 during reset, then move pin
    rst_lvl = 1; ea_lvl = 0;
    step("R5 capture");
    rst_lvl = 0; ea_lvl = 1;
    step("R5 hold");
    ea_lvl = 0; step("R5 hold");
    ea_lvl = 1; lock_bits = 3'b011; step("R3 level2");
    lock_bits = 3'b111; step("R4 level3");
    lock_bits = 3'b101; step("R2 level1");
    lock_bits = 3'b000; ea_lvl = 0; step("R7 live");

    // R8 R9: code read at each level
    for (int lv = 0; lv < 4; lv++) begin
      lock_bits = (lv == 0) ? 3'b000 : (lv == 1) ? 3'b001 : (lv == 2) ? 3'b011 : 3'b111;
      pins_verify(2'b11);
      addr = 12'h100 + 12'(lv); code_rdata = 8'h3C + 8'(lv);
      step("R8 R9 code read");
    end

    // R10: signature bytes at all levels
    for (int k = 0; k < 8; k++) begin
      lock_bits = 3'(k);
      pins_verify(2'b00);
      addr = 12'h030 + 12'(k % 4);
      step("R10 signature");
    end

    // R11: single-pin deviations
    lock_bits = 3'b000; addr = 12'h030;
    pins_verify(2'b01); step("R11 ctl 01");
    pins_verify(2'b10); step("R11 ctl 10");
    pins_verify(2'b00); pstrb_lvl = 1; step("R11 strobe");
    pins_verify(2'b00); alat_lvl = 0;  step("R11 latch pin");
    pins_verify(2'b00); hsel_lvl = 2'b01; step("R11 hsel");
    pins_verify(2'b11); rst_lvl = 0; step("R11 no reset");
    pins_verify(2'b11); ea_lvl = 0; step("R11 strap low");

    // mixed stimulus
    for (int n = 0; n < 600; n++) begin
      int kind;
      kind = $urandom % 4;
      lock_bits = 3'($urandom);
      fetch_ext = 1'($urandom);
      code_rdata = 8'($urandom);
      case ($urandom % 5)
        0: addr = 12'h030;
        1: addr = 12'h031;
        2: addr = 12'h032;
        3: addr = 12'h033;
        default: addr = 12'($urandom);
      endcase
      if (kind == 0) pins_verify(2'b11);
      else if (kind == 1) pins_verify(2'b00);
      else begin
        rst_lvl = 1'($urandom % 6 == 0); pstrb_lvl = 1'($urandom);
        alat_lvl = 1'($urandom); ea_lvl = 1'($urandom);
        hsel_lvl = 2'($urandom); ctl_lvl = 2'($urandom);
      end
      step("R1 R2 R3 R4 R5 R9 R10 R11 mixed");
    end

    // R12: asynchronous clear mid-run
    lock_bits = 3'b000; pins_verify(2'b00); addr = 12'h031;
    step("R10 pre-reset");
    rst_n = 0; #1;
    chk1("R12 async", "rd_data", rd_data, 0);
    chk1("R12 async", "rd_mode", rd_mode, 0);
    chk1("R12 async", "ea_latched_vld", ea_latched_vld, 0);
    pins_idle();
    @(negedge clk); rst_n = 1;
    repeat (3) step("R12 after");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R12 actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule